// File: doc/BRIEF.md
# Output Refresh Clock Selector

This block picks the clock that paces the periodic refresh of a bank of held analog outputs, and turns that clock into two single-cycle strobes in the system clock domain. The first strobe starts a refresh of the held values. The second opens the sample switches. The clock comes from one of two places. One is an internal oscillator, modelled as a divided system clock near 21 kHz. The other is an external clock taken from a shared bidirectional clock pin and brought into the system domain through a synchroniser.

A mode flag from the serial register bank makes the choice. When the flag is low, the internal oscillator paces the refresh, and if a separate drive-enable flag is set, the internal clock is driven out on the shared pin so that a second device can follow it. When the flag is high, the pin is only an input and is never driven. After reset the block uses the internal oscillator and leaves the pin high-impedance. A change of mode never creates an extra strobe.

Top module: `refresh_clk_sel`

## Requirements
- R1: While reset is high and in the first cycle after it, `osc_pin_oe`, `refresh_stb` and `switch_open_stb` are 0, and the block is in internal mode.
- R2: In internal mode the selected clock is `osc_pin_out`. It has a period of 2*HALF_DIV system cycles, where HALF_DIV = SYS_CLK_HZ/(2*OSC_HZ). Any window of whole periods therefore holds exactly one refresh strobe and one switch-open strobe per period.
- R3: In internal mode, `refresh_stb` is high exactly in the cycle after `osc_pin_out` falls, and `switch_open_stb` is high exactly in the cycle after it rises.
- R4: Each strobe is one system cycle wide, and the two strobes are never high in the same cycle.
- R5: In external mode, a falling edge on `osc_pin_in` gives a `refresh_stb` pulse, and a rising edge gives a `switch_open_stb` pulse. The pulse appears SYNC_STAGES+1 system cycles after the pin is sampled (3 with the default synchroniser).
- R6: In external mode the internal oscillator has no effect: with `osc_pin_in` held constant, no strobe occurs.
- R7: `osc_pin_oe` is 1 only when `ext_mode` is 0 and `drive_en` is 1, registered one cycle after those inputs. It is never 1 in external mode.
- R8: A change of `ext_mode` in either direction never adds a strobe. Every strobe comes from an edge of the source that was selected in the cycle the edge was detected.
- R9: In internal mode, activity on `osc_pin_in` has no effect on the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | Source flag from the register bank: 1 = external pin clock, 0 = internal oscillator |
| drive_en | input | 1 | Allows the internal clock to be driven out on the shared pin in internal mode |
| osc_pin_in | input | 1 | Input side of the shared clock pin (asynchronous) |
| osc_pin_out | output | 1 | Internal oscillator level, meant for the output side of the pin |
| osc_pin_oe | output | 1 | Output enable of the shared clock pin |
| refresh_stb | output | 1 | One-cycle strobe on each falling edge of the selected clock |
| switch_open_stb | output | 1 | One-cycle strobe on each rising edge of the selected clock |

## Verification
The hardest case to reach is a mode change that lands in the same cycle as an edge of the oscillator that is losing or gaining control, because that is exactly where a stray or lost strobe would come from. The bench repeats the switch at every phase of the internal period, with the external pin held alternately high and low. After switching to external mode it checks that no strobe appears. After switching back to internal mode it counts the strobes over a window of whole periods, so a stray strobe or a dropped one changes the count.

// File: rtl/refclk_pkg.sv
package refclk_pkg;

    typedef enum logic {
        SRC_INTERNAL = 1'b0,
        SRC_EXTERNAL = 1'b1
    } clk_src_e;

    localparam int NUM_SRC = 2;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_pulse_t;

    // Half period of the internal oscillator in system cycles, at least 2.
    function automatic int half_div(input int sys_hz, input int osc_hz);
        int h;
        h = sys_hz / (2 * osc_hz);
        return (h < 2) ? 2 : h;
    endfunction

    function automatic edge_pulse_t detect(input logic now_lvl, input logic old_lvl);
        edge_pulse_t e;
        e.rise = now_lvl & ~old_lvl;
        e.fall = ~now_lvl & old_lvl;
        return e;
    endfunction

endpackage

// File: rtl/refclk_int_osc.sv
module refclk_int_osc #(
    parameter int HALF_DIV = 1190
) (
    input  logic clk,
    input  logic rst,
    output logic lvl_o
);
    localparam int CNT_W = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lvl_o <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            lvl_o <= ~lvl_o;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/refclk_sync.sv
module refclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= 1'b0;
                    else     chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/refclk_edge_det.sv
module refclk_edge_det
    import refclk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        lvl_i,
    output edge_pulse_t edge_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl_i;
    end

    assign edge_o = detect(lvl_i, prev_q);
endmodule

// File: rtl/refresh_clk_sel.sv
module refresh_clk_sel
    import refclk_pkg::*;
#(
    parameter int SYS_CLK_HZ  = 50_000_000,
    parameter int OSC_HZ      = 21_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_mode,
    input  logic drive_en,
    input  logic osc_pin_in,
    output logic osc_pin_out,
    output logic osc_pin_oe,
    output logic refresh_stb,
    output logic switch_open_stb
);
    localparam int HALF_DIV = half_div(SYS_CLK_HZ, OSC_HZ);

    clk_src_e             mode_q;
    logic                 int_lvl;
    logic                 ext_lvl;
    logic [NUM_SRC-1:0]   src_lvl;
    edge_pulse_t          src_edge [NUM_SRC];
    edge_pulse_t          sel_edge;

    refclk_int_osc #(.HALF_DIV(HALF_DIV)) u_osc (
        .clk   (clk),
        .rst   (rst),
        .lvl_o (int_lvl)
    );

    refclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (osc_pin_in),
        .q_o (ext_lvl)
    );

    assign src_lvl[SRC_INTERNAL] = int_lvl;
    assign src_lvl[SRC_EXTERNAL] = ext_lvl;

    // One detector per source, always running; the mode picks among pulses.
    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_det
            refclk_edge_det u_det (
                .clk    (clk),
                .rst    (rst),
                .lvl_i  (src_lvl[g]),
                .edge_o (src_edge[g])
            );
        end
    endgenerate

    assign sel_edge = src_edge[mode_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q          <= SRC_INTERNAL;
            osc_pin_oe      <= 1'b0;
            refresh_stb     <= 1'b0;
            switch_open_stb <= 1'b0;
        end else begin
            mode_q          <= ext_mode ? SRC_EXTERNAL : SRC_INTERNAL;
            osc_pin_oe      <= drive_en & ~ext_mode;
            refresh_stb     <= sel_edge.fall;
            switch_open_stb <= sel_edge.rise;
        end
    end

    assign osc_pin_out = int_lvl;
endmodule

// File: rtl/refclk_chk.sv
module refclk_chk
    import refclk_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input clk_src_e mode_q,
    input logic     oe,
    input logic     refresh,
    input logic     open_sw
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (!oe && !refresh && !open_sw));

    // R4
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst) !(refresh && open_sw));

    // R4
    refresh_width_chk: assert property (@(posedge clk) disable iff (rst) refresh |=> !refresh);

    // R4
    open_width_chk: assert property (@(posedge clk) disable iff (rst) open_sw |=> !open_sw);

    // R7
    ext_no_drive_chk: assert property (@(posedge clk) disable iff (rst) (mode_q == SRC_EXTERNAL) |-> !oe);
endmodule

bind refresh_clk_sel refclk_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .mode_q  (mode_q),
    .oe      (osc_pin_oe),
    .refresh (refresh_stb),
    .open_sw (switch_open_stb)
);

// File: tb/refresh_clk_sel_tb.sv
module refresh_clk_sel_tb;
    localparam int SYS_HZ = 168_000;
    localparam int OSC_HZ = 21_000;
    localparam int HALF   = SYS_HZ / (2 * OSC_HZ);   // 4
    localparam int PER    = 2 * HALF;                // 8
    localparam int LAT    = 3;                       // two sync flops + output register

    logic clk = 1'b0;
    logic rst, ext_mode, drive_en, osc_pin_in;
    logic osc_pin_out, osc_pin_oe, refresh_stb, switch_open_stb;

    int checks = 0;
    int errors = 0;
    int overlaps = 0;

    always #10 clk = ~clk;

    refresh_clk_sel #(.SYS_CLK_HZ(SYS_HZ), .OSC_HZ(OSC_HZ), .SYNC_STAGES(2)) u_dut (
        .clk             (clk),
        .rst             (rst),
        .ext_mode        (ext_mode),
        .drive_en        (drive_en),
        .osc_pin_in      (osc_pin_in),
        .osc_pin_out     (osc_pin_out),
        .osc_pin_oe      (osc_pin_oe),
        .refresh_stb     (refresh_stb),
        .switch_open_stb (switch_open_stb)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (refresh_stb && switch_open_stb) overlaps++;
    endtask

    task automatic count_strobes(input int n, output int nf, output int nr);
        nf = 0; nr = 0;
        for (int i = 0; i < n; i++) begin
            step();
            nf += int'(refresh_stb);
            nr += int'(switch_open_stb);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; ext_mode = 1'b0; drive_en = 1'b0; osc_pin_in = 1'b0;
        repeat (3) step();
        chk(osc_pin_oe == 1'b0, "R1 oe in reset", osc_pin_oe, 0);
        chk(refresh_stb == 1'b0 && switch_open_stb == 1'b0, "R1 strobes in reset",
            refresh_stb + switch_open_stb, 0);
        rst = 1'b0;
        step();
        chk(osc_pin_oe == 1'b0, "R1 oe after reset", osc_pin_oe, 0);
    endtask

    task automatic t_internal();
        int nf = 0, nr = 0, tog = 0, bad = 0;
        logic h1, h2;
        drive_en = 1'b1;
        step();
        chk(osc_pin_oe == 1'b1, "R7 oe with drive_en in internal mode", osc_pin_oe, 1);
        step(); h2 = osc_pin_out;
        step(); h1 = osc_pin_out;
        for (int i = 0; i < 8 * PER; i++) begin
            osc_pin_in = ~osc_pin_in;            // R9: pin activity must be ignored
            step();
            if (refresh_stb !== (h2 & ~h1)) bad++;
            if (switch_open_stb !== (~h2 & h1)) bad++;
            nf += int'(refresh_stb);
            nr += int'(switch_open_stb);
            if (osc_pin_out != h1) tog++;
            h2 = h1; h1 = osc_pin_out;
        end
        osc_pin_in = 1'b0;
        chk(bad == 0, "R3 strobe placement vs internal clock", bad, 0);
        chk(nf == 8, "R2 refresh count over 8 periods", nf, 8);
        chk(nr == 8, "R2 switch-open count over 8 periods", nr, 8);
        chk(tog == 16, "R7 internal clock toggles on pin out", tog, 16);
        chk(bad == 0 && nf == 8, "R9 pin toggling ignored in internal mode", nf, 8);
    endtask

    task automatic t_external();
        int nf, nr;
        ext_mode = 1'b1;
        repeat (6) step();
        chk(osc_pin_oe == 1'b0, "R7 oe low in external mode", osc_pin_oe, 0);
        count_strobes(5 * PER, nf, nr);
        chk(nf + nr == 0, "R6 no strobes with static pin", nf + nr, 0);
        // rising pin edge
        osc_pin_in = 1'b1;
        repeat (LAT - 1) step();
        chk(switch_open_stb == 1'b0, "R5 switch-open not early", switch_open_stb, 0);
        step();
        chk(switch_open_stb == 1'b1 && refresh_stb == 1'b0, "R5 switch-open on pin rise",
            switch_open_stb, 1);
        step();
        chk(switch_open_stb == 1'b0, "R4 switch-open one cycle", switch_open_stb, 0);
        repeat (3) step();
        // falling pin edge
        osc_pin_in = 1'b0;
        repeat (LAT - 1) step();
        chk(refresh_stb == 1'b0, "R5 refresh not early", refresh_stb, 0);
        step();
        chk(refresh_stb == 1'b1 && switch_open_stb == 1'b0, "R5 refresh on pin fall",
            refresh_stb, 1);
        step();
        chk(refresh_stb == 1'b0, "R4 refresh one cycle", refresh_stb, 0);
        repeat (3) step();
        // periodic external clock, toggling every 3 cycles
        nf = 0; nr = 0;
        for (int t = 0; t < 20; t++) begin
            osc_pin_in = ~osc_pin_in;
            for (int k = 0; k < 3; k++) begin
                step();
                nf += int'(refresh_stb);
                nr += int'(switch_open_stb);
            end
        end
        for (int k = 0; k < LAT + 1; k++) begin
            step();
            nf += int'(refresh_stb);
            nr += int'(switch_open_stb);
        end
        chk(nf == 10 && nr == 10, "R5 external clock strobe count", nf * 100 + nr, 1010);
        ext_mode = 1'b0;
        repeat (PER) step();
    endtask

    task automatic t_switch();
        int nf, nr;
        for (int ph = 0; ph < PER; ph++) begin
            osc_pin_in = ph[0];
            repeat (PER + ph) step();
            ext_mode = 1'b1;
            step();
            count_strobes(10, nf, nr);
            chk(nf + nr == 0, "R8 no strobe after switch to external", nf + nr, 0);
            repeat (ph) step();
            ext_mode = 1'b0;
            step();
            count_strobes(8 * PER, nf, nr);
            chk(nf == 8 && nr == 8, "R8 exact strobes after switch to internal",
                nf * 100 + nr, 808);
        end
        osc_pin_in = 1'b0;
    endtask

    task automatic t_drive_off();
        drive_en = 1'b0;
        step();
        chk(osc_pin_oe == 1'b0, "R7 oe low without drive_en", osc_pin_oe, 0);
        drive_en = 1'b1;
        ext_mode = 1'b1;
        step();
        chk(osc_pin_oe == 1'b0, "R7 oe low in external mode with drive_en", osc_pin_oe, 0);
        ext_mode = 1'b0;
        step();
        chk(osc_pin_oe == 1'b1, "R7 oe back in internal mode", osc_pin_oe, 1);
    endtask

    initial begin
        #(200_000 * 20);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_internal();
        t_external();
        t_switch();
        t_drive_off();
        chk(overlaps == 0, "R4 strobes never together", overlaps, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule